// File: doc/BRIEF.md
# Segmented Base-Bound Address Translator

This unit sits on the address path between a processor and memory. Each virtual address that arrives is split into a segment selector, taken from its top bits, and an offset, taken from the rest. The selected entry of a small segment map supplies a base physical address, a bound and a read-only flag. In a single cycle the offset is compared with the bound while the base is added to the offset. The registered result is either a memory request carrying the physical address or a fault carrying a code and the offending virtual address.

The map entries and a relocation-enable flag are written through a configuration port that only accepts writes while the processor is in kernel mode. When the processor is in kernel mode and relocation is off, addresses pass through untouched so that the operating system can reach all of physical memory. In user mode translation always applies, whatever the relocation flag holds.

Top module: `segxlate_top`

## Requirements
- R1: After reset every segment has base 0, bound 0 and read-write access, relocation is off, and both `mem_valid` and `flt_valid` are low.
- R2: Bits [15:14] of `req_va` select one of four segments; bits [13:0] are the offset.
- R3: A translated access that does not fault yields `mem_pa` = (segment base + offset) modulo 2^20, with `mem_valid` high and `mem_wr` equal to `req_wr`, one clock after the request.
- R4: A translated access whose offset is greater than or equal to the segment bound (a 15-bit value, so 16384 admits the whole segment) gives fault code 1 (bound).
- R5: A translated write to a segment whose read-only flag is set gives fault code 2 (protection); reads of that segment translate normally.
- R6: When an access breaks both the bound and the read-only rule, the bound fault (code 1) is reported.
- R7: On a fault, `mem_valid` stays low, `flt_valid` is high, `flt_code` holds the nonzero code and `flt_va` holds the request's virtual address.
- R8: With `priv` high and relocation off, `mem_pa` is `req_va` zero-extended to 20 bits, and no bound or protection fault is raised.
- R9: With `priv` low, translation and checks apply even when relocation is off.
- R10: A configuration write presented with `priv` low changes no map entry and not the relocation flag.
- R11: `cfg_kind` picks the target: 0 writes base (`cfg_wdata` [19:0]), 1 writes bound ([14:0]), 2 writes the read-only flag ([0]), 3 writes the relocation-enable flag ([0]); `cfg_idx` names the segment for kinds 0 to 2. A write takes effect for requests from the next cycle on.
- R12: A cycle with `req_valid` low produces neither `mem_valid` nor `flt_valid` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv | input | 1 | Processor in kernel mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Configuration target selector |
| cfg_idx | input | 2 | Segment index for configuration |
| cfg_wdata | input | 20 | Configuration write data |
| req_valid | input | 1 | Access request present |
| req_wr | input | 1 | Access is a write |
| req_va | input | 16 | Virtual address of the access |
| mem_valid | output | 1 | Translated request to memory |
| mem_wr | output | 1 | Write flag of the memory request |
| mem_pa | output | 20 | Physical address of the memory request |
| flt_valid | output | 1 | Access faulted |
| flt_code | output | 2 | Fault code: 1 bound, 2 protection |
| flt_va | output | 16 | Virtual address that faulted |

## Verification
The bench builds the unit with its default widths: a 16-bit virtual address, two selector bits and a 20-bit physical address. With these values all four segments, the full-segment bound of 16384 and a base near the top of physical memory whose sum wraps are all reachable by directed cases, while random bases, bounds, privilege levels and read-only flags exercise the fault priority and the user-mode write refusal.

// File: rtl/segx_pkg.sv
package segx_pkg;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_BOUND = 2'd1,
        FLT_PROT  = 2'd2
    } flt_e;

    typedef enum logic [1:0] {
        CK_BASE  = 2'd0,
        CK_BOUND = 2'd1,
        CK_RO    = 2'd2,
        CK_RELOC = 2'd3
    } cfg_kind_e;

    // Bound violation outranks a protection violation.
    function automatic flt_e pick_fault(input logic over, input logic prot_hit);
        if (over)
            return FLT_BOUND;
        else if (prot_hit)
            return FLT_PROT;
        else
            return FLT_NONE;
    endfunction

endpackage

// File: rtl/seg_map.sv
module seg_map
    import segx_pkg::*;
#(
    parameter int SEG_W = 2,
    parameter int PA_W  = 20,
    parameter int BND_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             priv,
    input  logic             cfg_we,
    input  cfg_kind_e        cfg_kind,
    input  logic [SEG_W-1:0] cfg_idx,
    input  logic [PA_W-1:0]  cfg_wdata,
    input  logic [SEG_W-1:0] rd_idx,
    output logic [PA_W-1:0]  rd_base,
    output logic [BND_W-1:0] rd_bound,
    output logic             rd_ro,
    output logic             reloc_en
);
    localparam int NSEG = 1 << SEG_W;

    logic [PA_W-1:0]  base_q  [NSEG];
    logic [BND_W-1:0] bound_q [NSEG];
    logic             ro_q    [NSEG];
    logic             wr_ok;

    assign wr_ok = cfg_we && priv;

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g]  <= '0;
                bound_q[g] <= '0;
                ro_q[g]    <= 1'b0;
            end else if (wr_ok && (cfg_idx == SEG_W'(g))) begin
                case (cfg_kind)
                    CK_BASE:  base_q[g]  <= cfg_wdata;
                    CK_BOUND: bound_q[g] <= cfg_wdata[BND_W-1:0];
                    CK_RO:    ro_q[g]    <= cfg_wdata[0];
                    default:  ;
                endcase
            end
        end

        AST_USER_MAP_HELD: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && !priv) |=> ($stable(base_q[g]) && $stable(bound_q[g]) && $stable(ro_q[g]))); // R10
    end

    always_ff @(posedge clk) begin
        if (rst)
            reloc_en <= 1'b0;
        else if (wr_ok && cfg_kind == CK_RELOC)
            reloc_en <= cfg_wdata[0];
    end

    assign rd_base  = base_q[rd_idx];
    assign rd_bound = bound_q[rd_idx];
    assign rd_ro    = ro_q[rd_idx];

    AST_USER_RELOC_HELD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !priv) |=> $stable(reloc_en)); // R10

endmodule

// File: rtl/seg_check.sv
module seg_check
    import segx_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int SEG_W = 2,
    parameter int PA_W  = 20,
    parameter int BND_W = 15
) (
    input  logic [VA_W-1:0]  va,
    input  logic             wr,
    input  logic             bypass,
    input  logic [PA_W-1:0]  base,
    input  logic [BND_W-1:0] bound,
    input  logic             ro,
    output logic [PA_W-1:0]  pa,
    output flt_e             code
);
    localparam int OFF_W = VA_W - SEG_W;

    logic [OFF_W-1:0] offset;
    logic [PA_W-1:0]  sum;
    logic             over;

    assign offset = va[OFF_W-1:0];

    // Compare and add are independent, both in the same cycle.
    assign over = BND_W'(offset) >= bound;
    assign sum  = base + PA_W'(offset);

    always_comb begin
        if (bypass) begin
            pa   = PA_W'(va);
            code = FLT_NONE;
        end else begin
            pa   = sum;
            code = pick_fault(over, wr && ro);
        end
    end

endmodule

// File: rtl/seg_out_reg.sv
module seg_out_reg
    import segx_pkg::*;
#(
    parameter int VA_W = 16,
    parameter int PA_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_wr,
    input  logic [VA_W-1:0] req_va,
    input  logic [PA_W-1:0] pa,
    input  flt_e            code,
    output logic            mem_valid,
    output logic            mem_wr,
    output logic [PA_W-1:0] mem_pa,
    output logic            flt_valid,
    output flt_e            flt_code,
    output logic [VA_W-1:0] flt_va
);
    logic ok;
    assign ok = (code == FLT_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
            mem_wr    <= 1'b0;
            mem_pa    <= '0;
            flt_valid <= 1'b0;
            flt_code  <= FLT_NONE;
            flt_va    <= '0;
        end else begin
            mem_valid <= req_valid && ok;
            mem_wr    <= req_valid && ok && req_wr;
            mem_pa    <= (req_valid && ok) ? pa : '0;
            flt_valid <= req_valid && !ok;
            flt_code  <= (req_valid && !ok) ? code : FLT_NONE;
            flt_va    <= (req_valid && !ok) ? req_va : '0;
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(mem_valid && flt_valid)); // R7
    AST_FAULT_CODED: assert property (@(posedge clk) disable iff (rst)
        flt_valid |-> (flt_code != FLT_NONE)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!mem_valid && !flt_valid)); // R12

endmodule

// File: rtl/segxlate_top.sv
module segxlate_top
    import segx_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int SEG_W = 2,
    parameter int PA_W  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             priv,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_kind,
    input  logic [SEG_W-1:0] cfg_idx,
    input  logic [PA_W-1:0]  cfg_wdata,
    input  logic             req_valid,
    input  logic             req_wr,
    input  logic [VA_W-1:0]  req_va,
    output logic             mem_valid,
    output logic             mem_wr,
    output logic [PA_W-1:0]  mem_pa,
    output logic             flt_valid,
    output logic [1:0]       flt_code,
    output logic [VA_W-1:0]  flt_va
);
    localparam int OFF_W = VA_W - SEG_W;
    localparam int BND_W = OFF_W + 1;

    logic [PA_W-1:0]  ent_base;
    logic [BND_W-1:0] ent_bound;
    logic             ent_ro;
    logic             reloc_en;
    logic             bypass;
    logic [PA_W-1:0]  xl_pa;
    flt_e             xl_code;
    flt_e             flt_code_e;

    assign bypass = priv && !reloc_en;

    seg_map #(.SEG_W(SEG_W), .PA_W(PA_W), .BND_W(BND_W)) u_map (
        .clk      (clk),
        .rst      (rst),
        .priv     (priv),
        .cfg_we   (cfg_we),
        .cfg_kind (cfg_kind_e'(cfg_kind)),
        .cfg_idx  (cfg_idx),
        .cfg_wdata(cfg_wdata),
        .rd_idx   (req_va[VA_W-1 -: SEG_W]),
        .rd_base  (ent_base),
        .rd_bound (ent_bound),
        .rd_ro    (ent_ro),
        .reloc_en (reloc_en)
    );

    seg_check #(.VA_W(VA_W), .SEG_W(SEG_W), .PA_W(PA_W), .BND_W(BND_W)) u_chk (
        .va    (req_va),
        .wr    (req_wr),
        .bypass(bypass),
        .base  (ent_base),
        .bound (ent_bound),
        .ro    (ent_ro),
        .pa    (xl_pa),
        .code  (xl_code)
    );

    seg_out_reg #(.VA_W(VA_W), .PA_W(PA_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_wr   (req_wr),
        .req_va   (req_va),
        .pa       (xl_pa),
        .code     (xl_code),
        .mem_valid(mem_valid),
        .mem_wr   (mem_wr),
        .mem_pa   (mem_pa),
        .flt_valid(flt_valid),
        .flt_code (flt_code_e),
        .flt_va   (flt_va)
    );

    assign flt_code = flt_code_e;

    AST_BYPASS_IDENT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && priv && !reloc_en) |=> (mem_valid && mem_pa == PA_W'($past(req_va)))); // R8
    AST_FAULT_VA: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !bypass) |=> (!flt_valid || flt_va == $past(req_va))); // R7
    AST_USER_CHECKED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !priv && ent_bound == '0) |=> (flt_valid && flt_code == 2'd1)); // R9

endmodule

// File: tb/sim_segxlate_top.sv
module sim_segxlate_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        priv, cfg_we, req_valid, req_wr;
    logic [1:0]  cfg_kind, cfg_idx;
    logic [19:0] cfg_wdata;
    logic [15:0] req_va;
    logic        mem_valid, mem_wr, flt_valid;
    logic [19:0] mem_pa;
    logic [1:0]  flt_code;
    logic [15:0] flt_va;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [19:0] m_base  [4];
    logic [14:0] m_bound [4];
    logic        m_ro    [4];
    logic        m_reloc;

    always #5 clk = ~clk;

    segxlate_top u0 (
        .clk(clk), .rst(rst), .priv(priv), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_wr(req_wr), .req_va(req_va), .mem_valid(mem_valid), .mem_wr(mem_wr),
        .mem_pa(mem_pa), .flt_valid(flt_valid), .flt_code(flt_code), .flt_va(flt_va)
    );

    task automatic check(input string tag, input bit ok, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_bound[i] = '0; m_ro[i] = 1'b0;
        end
        m_reloc = 1'b0;
    endtask

    // Expected outcome from the requirements.
    task automatic expect_of(input logic p, input logic w, input logic [15:0] va,
                             output logic e_mv, output logic [19:0] e_pa, output logic [1:0] e_code);
        logic [1:0]  s;
        logic [13:0] off;
        s = va[15:14];
        off = va[13:0];
        e_mv = 1'b1; e_code = 2'd0; e_pa = {4'b0, va};
        if (!(p && !m_reloc)) begin
            if ({1'b0, off} >= m_bound[s]) begin
                e_mv = 1'b0; e_code = 2'd1;
            end else if (w && m_ro[s]) begin
                e_mv = 1'b0; e_code = 2'd2;
            end else begin
                e_pa = m_base[s] + {6'b0, off};
            end
        end
    endtask

    task automatic cfg_write(input logic p, input logic [1:0] k, input logic [1:0] idx, input logic [19:0] d);
        @(negedge clk);
        priv = p; cfg_we = 1'b1; cfg_kind = k; cfg_idx = idx; cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (p) begin
            case (k)
                2'd0: m_base[idx]  = d;
                2'd1: m_bound[idx] = d[14:0];
                2'd2: m_ro[idx]    = d[0];
                default: m_reloc   = d[0];
            endcase
        end
    endtask

    task automatic access(input string tag, input logic p, input logic w, input logic [15:0] va);
        logic e_mv;
        logic [19:0] e_pa;
        logic [1:0] e_code;
        expect_of(p, w, va, e_mv, e_pa, e_code);
        @(negedge clk);
        priv = p; req_valid = 1'b1; req_wr = w; req_va = va;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (e_mv)
            check(tag, mem_valid && !flt_valid && mem_pa == e_pa && mem_wr == w,
                  $sformatf("mv=%0b fv=%0b pa=%h wr=%0b", mem_valid, flt_valid, mem_pa, mem_wr),
                  $sformatf("mv=1 fv=0 pa=%h wr=%0b", e_pa, w));
        else
            check(tag, !mem_valid && flt_valid && flt_code == e_code && flt_va == va,
                  $sformatf("mv=%0b fv=%0b code=%0d va=%h", mem_valid, flt_valid, flt_code, flt_va),
                  $sformatf("mv=0 fv=1 code=%0d va=%h", e_code, va));
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        check(tag, !mem_valid && !flt_valid,
              $sformatf("mv=%0b fv=%0b", mem_valid, flt_valid), "mv=0 fv=0");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; priv = 0; cfg_we = 0; cfg_kind = 0; cfg_idx = 0; cfg_wdata = 0;
        req_valid = 0; req_wr = 0; req_va = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 idle after reset", !mem_valid && !flt_valid,
              $sformatf("mv=%0b fv=%0b", mem_valid, flt_valid), "mv=0 fv=0");
        @(negedge clk);
        rst = 1'b0;

        access("R1 user bound zero", 1'b0, 1'b0, 16'h0000);
        access("R1 R8 kernel bypass at reset", 1'b1, 1'b1, 16'hC123);
        access("R9 user translates with relocation off", 1'b0, 1'b0, 16'h8010);

        cfg_write(1, 2'd0, 2'd0, 20'h10000);
        cfg_write(1, 2'd1, 2'd0, 20'h00100);
        cfg_write(1, 2'd0, 2'd1, 20'hFF000);
        cfg_write(1, 2'd1, 2'd1, 20'h04000);
        cfg_write(1, 2'd0, 2'd2, 20'h20000);
        cfg_write(1, 2'd1, 2'd2, 20'h02000);
        cfg_write(1, 2'd2, 2'd2, 20'h00001);
        cfg_write(1, 2'd0, 2'd3, 20'h00005);
        cfg_write(1, 2'd1, 2'd3, 20'h03FFF);

        access("R3 seg0 translate", 1'b0, 1'b0, 16'h00FF);
        access("R4 seg0 offset equals bound", 1'b0, 1'b0, 16'h0100);
        access("R3 R4 seg1 full bound wraps", 1'b0, 1'b1, 16'h7FFF);
        access("R2 seg3 offset zero", 1'b0, 1'b0, 16'hC000);
        access("R4 seg3 last offset faults", 1'b0, 1'b0, 16'hFFFF);
        access("R5 read of read-only", 1'b0, 1'b0, 16'h8123);
        access("R5 write to read-only", 1'b0, 1'b1, 16'h8123);
        access("R6 bound outranks protection", 1'b0, 1'b1, 16'hA000);
        idle_check("R12 no request");

        cfg_write(0, 2'd0, 2'd0, 20'h00000);
        cfg_write(0, 2'd1, 2'd0, 20'h03FFF);
        access("R10 user map write ignored", 1'b0, 1'b0, 16'h00FF);
        access("R10 user bound write ignored", 1'b0, 1'b0, 16'h0200);

        cfg_write(1, 2'd3, 2'd0, 20'h00001);
        access("R11 kernel translates with relocation on", 1'b1, 1'b0, 16'h0010);
        cfg_write(0, 2'd3, 2'd0, 20'h00000);
        access("R10 user cannot clear relocation", 1'b1, 1'b0, 16'h0020);
        cfg_write(1, 2'd3, 2'd0, 20'h00000);
        access("R8 kernel bypass after clearing", 1'b1, 1'b0, 16'h0300);
        access("R9 user still translated", 1'b0, 1'b0, 16'h0300);

        for (int n = 0; n < 600; n++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 3) begin
                logic [19:0] d;
                d = (op == 0) ? 20'($urandom) : 20'($urandom_range(0, 16384));
                cfg_write(1'($urandom_range(0, 3) != 0), 2'($urandom), 2'($urandom), d);
            end else if (op == 3) begin
                idle_check("R12 random idle");
            end else begin
                access("R3 R4 R5 R6 R7 R9 random", 1'($urandom), 1'($urandom), 16'($urandom));
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule